// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Triggered Commit

The block divides an input clock by a programmable fractional ratio. It does this by producing a one-cycle clock-enable pulse stream, so that downstream logic on the same clock advances at the divided rate. Software writes a divider field into a control word held as a shadow copy. The running divider keeps using its active value until software sets a trigger bit. That bit reads back as 1 until the new value has been adopted. After that it clears without further action.

The divisor uses an offset, fixed-point encoding. In units of 2^FRAC_W, the divisor equals the stored field plus 2^FRAC_W. A field of zero therefore divides by exactly 1.0, and a field of all ones gives the largest ratio. A phase accumulator performs the division. On every enabled input cycle it adds 2^FRAC_W. Whenever the sum reaches the divisor, it subtracts the divisor and emits an enable pulse.

A fixed pre-divider of PRE_DIV input cycles feeds the accumulator, so the output rate is the input rate divided first by PRE_DIV and then by the divisor. The clock-gate input freezes the whole chain. A commit that is waiting for the gate stays pending until the gate turns on again. The commit is applied only on a cycle that emits a pulse, so no output period is ever cut short.

The commit controller has three states:
- `ST_IDLE`: nothing is pending. A trigger write moves it to `ST_WAIT_GATE`.
- `ST_WAIT_GATE`: the gate is off. When the gate turns on, it moves to `ST_WAIT_EDGE`.
- `ST_WAIT_EDGE`: it waits for the next output pulse.
  - On that pulse, the shadow field becomes active and the controller returns to `ST_IDLE`.
  - If the gate turns off first, it falls back to `ST_WAIT_GATE`.

Top module: `clk_frac_divider`

## Requirements
- R1: The divisor is (field + 2^FRAC_W) / 2^FRAC_W. An active field of 0 gives one enable pulse on every gated-on cycle.
- R2: Over any window of N enabled cycles, the pulse count is within one of N*2^FRAC_W/D, where D = field + 2^FRAC_W. Successive pulses are floor(D/2^FRAC_W) or ceil(D/2^FRAC_W) cycles apart.
- R3: The control word sits at address 0, and the divider field occupies bits [FIELD_SHIFT+WIDTH-1:FIELD_SHIFT]. A write changes only the bits set in wr_mask_i, and all 32 bits read back.
- R4: Writing the field alone does not change the output rate.
- R5: A write of 1 to bit TRIG_BIT at address 1 sets the trigger. That bit reads 1 while the commit is pending and clears by itself once the commit is applied. A write of 0 to it has no effect.
- R6: While gate_en_i is low, clk_en_o stays low and a pending trigger remains pending.
- R7: The commit happens on an output pulse: in the first cycle in which the trigger bit reads 0, clk_en_o is 1.
- R8: With PRE_DIV > 1, the output rate is the input rate / (PRE_DIV * D/2^FRAC_W), within two pulses over a window.
- R9: After reset, the control word reads CTRL_RESET, the trigger bit reads 0 and clk_en_o is 0.
- R10: A field of all ones divides by ((2^WIDTH - 1) + 2^FRAC_W) / 2^FRAC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en_i | input | 1 | Clock gate; low freezes division and commit |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 control word, 1 trigger |
| wr_data_i | input | 32 | Write data |
| wr_mask_i | input | 32 | Per-bit write enable |
| rd_addr_i | input | 1 | Read address |
| rd_data_o | output | 32 | Read data (combinational) |
| clk_en_o | output | 1 | Divided clock-enable pulse |

## Verification
A wrong accumulator value or divisor shows up at clk_en_o within one output period. It appears as a gap between pulses outside the floor/ceil bounds, and the pulse count over the window drifts by more than one. A commit controller stuck in a state shows on the trigger bit at address 1: it either never clears, or it clears on a cycle with no pulse. The bench catches both of these on the first commit it issues. A stale shadow or a mask error is visible on the very next read of address 0.

// File: rtl/fdiv_pkg.sv
`timescale 1ns/1ps
package fdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_GATE = 2'd1,
        ST_WAIT_EDGE = 2'd2
    } commit_state_e;

    localparam int CTRL_ADDR = 0;
    localparam int TRIG_ADDR = 1;

    function automatic logic [31:0] field_mask(input int shift, input int width);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (i >= shift && i < shift + width) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/fdiv_regs.sv
`timescale 1ns/1ps
module fdiv_regs #(
    parameter int          WIDTH       = 8,
    parameter int          FIELD_SHIFT = 4,
    parameter int          TRIG_BIT    = 0,
    parameter logic [31:0] CTRL_RESET  = 32'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_addr_i,
    input  logic [31:0]      wr_data_i,
    input  logic [31:0]      wr_mask_i,
    input  logic             rd_addr_i,
    input  logic             pending_i,
    output logic [31:0]      rd_data_o,
    output logic [WIDTH-1:0] shadow_field_o,
    output logic             trig_set_o
);
    import fdiv_pkg::*;

    logic [31:0] ctrl_q;
    logic        ctrl_wr;

    assign ctrl_wr    = wr_en_i && (wr_addr_i == 1'(CTRL_ADDR));
    assign trig_set_o = wr_en_i && (wr_addr_i == 1'(TRIG_ADDR))
                        && wr_mask_i[TRIG_BIT] && wr_data_i[TRIG_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (ctrl_wr) begin
            ctrl_q <= (ctrl_q & ~wr_mask_i) | (wr_data_i & wr_mask_i);
        end
    end

    assign shadow_field_o = ctrl_q[FIELD_SHIFT +: WIDTH];

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == 1'(CTRL_ADDR)) begin
            rd_data_o = ctrl_q;
        end else begin
            rd_data_o[TRIG_BIT] = pending_i;
        end
    end

    // R3: unmasked bits survive a control-word write
    a_r3_unmasked_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ((ctrl_q & ~$past(wr_mask_i)) == ($past(ctrl_q) & ~$past(wr_mask_i))));

endmodule

// File: rtl/fdiv_commit_fsm.sv
`timescale 1ns/1ps
module fdiv_commit_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_set_i,
    input  logic gate_en_i,
    input  logic pulse_now_i,
    output logic pending_o,
    output logic load_o
);
    import fdiv_pkg::*;

    commit_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_set_i) state_d = ST_WAIT_GATE;
            end
            ST_WAIT_GATE: begin
                if (gate_en_i) state_d = ST_WAIT_EDGE;
            end
            ST_WAIT_EDGE: begin
                if (!gate_en_i)       state_d = ST_WAIT_GATE;
                else if (pulse_now_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pending_o = (state_q != ST_IDLE);
        load_o    = (state_q == ST_WAIT_EDGE) && gate_en_i && pulse_now_i;
    end

    // R6: a pending commit is never dropped while the gate is off
    a_r6_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !gate_en_i) |=> pending_o);

    // R5: a trigger always leaves the idle state
    a_r5_trigger_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending_o && trig_set_i) |=> pending_o);

endmodule

// File: rtl/fdiv_prediv.sv
`timescale 1ns/1ps
module fdiv_prediv #(
    parameter int PRE_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en_i,
    output logic step_o
);
    localparam int CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (gate_en_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign step_o = gate_en_i && (cnt_q == LAST);

    // R8: the pre-divider count stays within its modulus
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/fdiv_phase_acc.sv
`timescale 1ns/1ps
module fdiv_phase_acc #(
    parameter int              WIDTH       = 8,
    parameter int              FRAC_W      = 3,
    parameter logic [WIDTH-1:0] RESET_FIELD = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_field_i,
    output logic             pulse_now_o,
    output logic             clk_en_o
);
    localparam int ACC_W = WIDTH + 2;
    localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

    logic [WIDTH-1:0] active_q;
    logic [ACC_W-1:0] acc_q, acc_d, sum_w, divisor_w;

    assign divisor_w   = ACC_W'(active_q) + ONE;
    assign sum_w       = acc_q + ONE;
    assign pulse_now_o = step_i && (sum_w >= divisor_w);

    always_comb begin
        acc_d = acc_q;
        if (step_i) acc_d = pulse_now_o ? (sum_w - divisor_w) : sum_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            active_q <= RESET_FIELD;
            clk_en_o <= 1'b0;
        end else begin
            acc_q    <= acc_d;
            clk_en_o <= pulse_now_o;
            if (load_i) active_q <= load_field_i;
        end
    end

    // R7: the phase never reaches the active divisor, even across a switch
    a_r7_acc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < divisor_w);

endmodule

// File: rtl/clk_frac_divider.sv
`timescale 1ns/1ps
module clk_frac_divider #(
    parameter int          WIDTH       = 8,
    parameter int          FRAC_W      = 3,
    parameter int          FIELD_SHIFT = 4,
    parameter int          TRIG_BIT    = 0,
    parameter int          PRE_DIV     = 1,
    parameter logic [31:0] CTRL_RESET  = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        gate_en_i,
    input  logic        wr_en_i,
    input  logic        wr_addr_i,
    input  logic [31:0] wr_data_i,
    input  logic [31:0] wr_mask_i,
    input  logic        rd_addr_i,
    output logic [31:0] rd_data_o,
    output logic        clk_en_o
);
    localparam logic [WIDTH-1:0] RESET_FIELD = WIDTH'(CTRL_RESET >> FIELD_SHIFT);

    logic [WIDTH-1:0] shadow_field;
    logic             trig_set, pending, load, step, pulse_now;

    fdiv_regs #(
        .WIDTH(WIDTH), .FIELD_SHIFT(FIELD_SHIFT),
        .TRIG_BIT(TRIG_BIT), .CTRL_RESET(CTRL_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .wr_mask_i(wr_mask_i),
        .rd_addr_i(rd_addr_i), .pending_i(pending),
        .rd_data_o(rd_data_o), .shadow_field_o(shadow_field),
        .trig_set_o(trig_set)
    );

    fdiv_commit_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .trig_set_i(trig_set), .gate_en_i(gate_en_i),
        .pulse_now_i(pulse_now),
        .pending_o(pending), .load_o(load)
    );

    fdiv_prediv #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n),
        .gate_en_i(gate_en_i), .step_o(step)
    );

    fdiv_phase_acc #(
        .WIDTH(WIDTH), .FRAC_W(FRAC_W), .RESET_FIELD(RESET_FIELD)
    ) u_acc (
        .clk(clk), .rst_n(rst_n),
        .step_i(step), .load_i(load), .load_field_i(shadow_field),
        .pulse_now_o(pulse_now), .clk_en_o(clk_en_o)
    );

    // R7: a commit is only taken on a cycle that emits a pulse
    a_r7_load_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> pulse_now);

    // R6: no enable pulse follows a gated-off cycle
    a_r6_gate_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en_i |=> !clk_en_o);

endmodule

// File: tb/clk_frac_divider_tb_top.sv
`timescale 1ns/1ps
module clk_frac_divider_tb_top;

    localparam int W = 8;
    localparam int F = 3;
    localparam int SH = 4;
    localparam int TB = 0;
    localparam int PD = 3;
    localparam logic [31:0] FMASK = 32'h0000_0FF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gate_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] wr_mask = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data, rd_data_pre;
    logic        clk_en, clk_en_pre;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clk_frac_divider #(.WIDTH(W), .FRAC_W(F), .FIELD_SHIFT(SH), .TRIG_BIT(TB),
                       .PRE_DIV(1), .CTRL_RESET(32'h0)) dut_i (
        .clk(clk), .rst_n(rst_n), .gate_en_i(gate_en), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_mask_i(wr_mask),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .clk_en_o(clk_en));

    clk_frac_divider #(.WIDTH(W), .FRAC_W(F), .FIELD_SHIFT(SH), .TRIG_BIT(TB),
                       .PRE_DIV(PD), .CTRL_RESET(32'h0)) dut_pre_i (
        .clk(clk), .rst_n(rst_n), .gate_en_i(gate_en), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_mask_i(wr_mask),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data_pre), .clk_en_o(clk_en_pre));

    function automatic int scaled_div(input int field);
        return field + (1 << F);
    endfunction

    function automatic real ideal_count(input int n, input int d, input int pre);
        return (real'(n) * real'(1 << F)) / (real'(d) * real'(pre));
    endfunction

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_near(input string tag, input int act, input real exp, input real tol);
        real diff;
        checks++;
        diff = real'(act) - exp;
        if (diff < 0.0) diff = -diff;
        if (diff > tol) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%f", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic addr, input logic [31:0] data, input logic [31:0] mask);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data; wr_mask = mask;
        @(negedge clk);
        wr_en = 1'b0; wr_mask = '0;
    endtask

    task automatic bus_read(input logic addr, output logic [31:0] d, output logic [31:0] dp);
        rd_addr = addr;
        #1;
        d = rd_data;
        dp = rd_data_pre;
    endtask

    // Waits for both instances to finish a commit; reports dut_i's enable at its clear cycle.
    task automatic wait_commit(output bit ok, output bit edge_pulse);
        bit seen = 1'b0;
        ok = 1'b0;
        edge_pulse = 1'b0;
        for (int i = 0; i < 8000; i++) begin
            @(negedge clk);
            rd_addr = 1'b1;
            #1;
            if (!seen && !rd_data[TB]) begin
                seen = 1'b1;
                edge_pulse = clk_en;
            end
            if (!rd_data[TB] && !rd_data_pre[TB]) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic measure(input int n, input int d, output int cnt, output int cnt_pre, output int bad_gaps);
        int last = -1;
        int lo = d / (1 << F);
        int hi = (d + (1 << F) - 1) / (1 << F);
        cnt = 0; cnt_pre = 0; bad_gaps = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            if (clk_en_pre) cnt_pre++;
            if (clk_en) begin
                cnt++;
                if (last >= 0 && ((i - last) < lo || (i - last) > hi)) bad_gaps++;
                last = i;
            end
        end
    endtask

    task automatic program_and_check(input int field, input int n, input string tag);
        bit ok, edge_pulse;
        int c, cp, bg, d;
        d = scaled_div(field);
        bus_write(1'b0, 32'(field) << SH, FMASK);
        bus_write(1'b1, 32'(1) << TB, 32'(1) << TB);
        wait_commit(ok, edge_pulse);
        chk_eq({tag, " R5 trigger self-clears"}, ok, 1);
        chk_eq({tag, " R7 commit on pulse"}, edge_pulse, 1);
        measure(n, d, c, cp, bg);
        chk_near({tag, " R2 pulse count"}, c, ideal_count(n, d, 1), 1.0);
        chk_eq({tag, " R2 pulse spacing"}, bg, 0);
        chk_near({tag, " R8 prediv pulse count"}, cp, ideal_count(n, d, PD), 2.0);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] d0, dp0;
        int c, cp, bg;
        bit ok, edge_pulse;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        @(negedge clk);
        bus_read(1'b0, d0, dp0);
        chk_eq("R9 control word reset", d0, 32'h0);
        bus_read(1'b1, d0, dp0);
        chk_eq("R9 trigger reads 0", d0[TB], 0);
        measure(16, 8, c, cp, bg);
        chk_eq("R9/R6 no pulses while gated off", c + cp, 0);

        // R1: field 0 divides by one
        gate_en = 1'b1;
        @(negedge clk);
        measure(64, 8, c, cp, bg);
        chk_eq("R1 divide by 1.0", c, 64);
        chk_near("R8 prediv at field 0", cp, ideal_count(64, 8, PD), 1.0);

        // R3: masked writes
        bus_write(1'b0, 32'hA5A5_A5A5, 32'hFFFF_FFFF);
        bus_read(1'b0, d0, dp0);
        chk_eq("R3 full write readback", d0, 32'hA5A5_A5A5);
        bus_write(1'b0, 32'h0000_0130, FMASK);
        bus_read(1'b0, d0, dp0);
        chk_eq("R3 field-only write keeps others", d0, 32'hA5A5_A135);

        // R4: shadow only, rate unchanged
        measure(64, 8, c, cp, bg);
        chk_eq("R4 no effect before trigger", c, 64);

        // R5: writing 0 to the trigger does nothing
        bus_write(1'b1, 32'h0, 32'(1) << TB);
        bus_read(1'b1, d0, dp0);
        chk_eq("R5 zero write leaves trigger clear", d0[TB], 0);
        measure(32, 8, c, cp, bg);
        chk_eq("R5 zero write keeps rate", c, 32);

        // R5: trigger reads pending, then commits field 0x13
        bus_write(1'b1, 32'(1) << TB, 32'(1) << TB);
        bus_read(1'b1, d0, dp0);
        chk_eq("R5 trigger reads pending", d0[TB], 1);
        wait_commit(ok, edge_pulse);
        chk_eq("R5 trigger clears", ok, 1);
        chk_eq("R7 commit on pulse", edge_pulse, 1);
        measure(3000, scaled_div(8'h13), c, cp, bg);
        chk_near("R2 count at field 0x13", c, ideal_count(3000, scaled_div(8'h13), 1), 1.0);
        chk_eq("R2 spacing at field 0x13", bg, 0);
        chk_near("R8 prediv at field 0x13", cp, ideal_count(3000, scaled_div(8'h13), PD), 2.0);

        // R6: trigger with gate off stays pending, outputs quiet
        bus_write(1'b0, 32'h0000_0400, FMASK);
        gate_en = 1'b0;
        bus_write(1'b1, 32'(1) << TB, 32'(1) << TB);
        c = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            rd_addr = 1'b1;
            #1;
            if (!rd_data[TB] || clk_en) c++;
        end
        chk_eq("R6 pending held and quiet while gated", c, 0);
        gate_en = 1'b1;
        wait_commit(ok, edge_pulse);
        chk_eq("R6 commit after gate on", ok, 1);
        chk_eq("R7 commit on pulse after gate", edge_pulse, 1);
        measure(2000, scaled_div(8'h40), c, cp, bg);
        chk_near("R2 count at field 0x40", c, ideal_count(2000, scaled_div(8'h40), 1), 1.0);
        chk_eq("R2 spacing at field 0x40", bg, 0);

        // R10: largest field
        program_and_check(255, 5000, "R10 max field");

        // R1: back to divide by one via trigger
        program_and_check(0, 200, "R1 field 0 recommit");

        // R2/R8: random fields
        for (int k = 0; k < 6; k++) begin
            program_and_check(int'($urandom_range(0, 255)), 2500, "R2 random field");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule